// File: doc/BRIEF.md
# Bus-Interfaced Successive-Approximation Conversion Control

This block is the digital side of a successive-approximation converter that sits on a host bus. It decodes three control inputs into two actions. Chip enable high, chip select low and the read/convert line low request a conversion. The same two chip lines with read/convert high request a read. A conversion starts on the cycle in which the convert request first becomes true, so the order in which the three inputs settle does not matter. While the conversion runs, the busy output is high. The register resolves one bit per clock, most significant bit first, from a comparator decision supplied on an input.

A single byte-select line has two jobs. It is sampled when a conversion starts, and picks either a full 12-bit cycle or a shortened 8-bit cycle. During a read it picks which half of the result appears on the bus. With the format input high, all 12 lines are driven at once. With the format input low, a read returns either the upper eight bits on the top eight lines, or the four low bits with zeros forced on the four lines above them. This lets an 8-bit host read a full result in two bytes.

The bus is modelled as a value vector plus a per-line drive-enable vector. A pad ring turns these into tri-state pins. With chip enable tied high and chip select tied low, the block also runs standalone from the read/convert line alone.

Top module: `adc_bus_ctrl`

## Requirements
- R1: When idle, a conversion starts on the first clock at which chipEn=1, chipSelN=0 and readConv=0 all hold, whichever input arrived last. Busy is high from the following cycle. Holding that condition after completion does not start another conversion.
- R2: byteSel is captured at start. Value 0 keeps busy high for exactly 12 cycles and value 1 for exactly 8 cycles. Changing byteSel during the conversion does not change that length.
- R3: The result is resolved MSB first, one bit per cycle. Bit 11-k takes the comparator input of decision cycle k. After a short cycle, result bits 3:0 are zero.
- R4: Busy is 0 after reset and returns to 0 at completion. The result register resets to zero.
- R5: The result is held unchanged and can be read any number of times until another conversion completes.
- R6: A read with fullWidth=1 drives all 12 lines (drive mask 0xFFF) with the result.
- R7: A read with fullWidth=0 and byteSel=0 drives lines 11:4 with result bits 11:4 and leaves lines 3:0 undriven (drive mask 0xFF0).
- R8: A read with fullWidth=0 and byteSel=1 drives lines 3:0 with result bits 3:0 and drives zeros on lines 7:4. Lines 11:8 are undriven (drive mask 0x0FF).
- R9: No line is driven unless the read request holds and no conversion is running.
- R10: A new convert request edge that arrives while busy is ignored and does not restart or lengthen the conversion.
- R11: With chipEn=1 and chipSelN=0 fixed, a one-cycle low pulse on readConv starts a conversion and the result appears on the bus at completion with no further input change. If readConv is instead left low, the bus stays undriven after completion until readConv returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the bit-decision clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Chip enable, active high |
| chipSelN | input | 1 | Chip select, active low |
| readConv | input | 1 | 1 = read request, 0 = convert request |
| byteSel | input | 1 | Cycle length at start (0 = 12 bits, 1 = 8 bits); byte choice on reads |
| fullWidth | input | 1 | 1 = read all 12 lines, 0 = read in two byte halves |
| cmpIn | input | 1 | Comparator decision for the current trial bit (1 = keep) |
| busy | output | 1 | High while a conversion runs |
| dataOut | output | 12 | Bus line values |
| dataDrv | output | 12 | Per-line drive enable; 0 means high impedance |

## Verification
The hardest situation to reach is a conversion that is disturbed while it runs. The stimulus drops chip enable and raises it again in the middle of a conversion, which creates a fresh convert-request edge. In the same window it flips byteSel. Busy must then still span exactly the 12 cycles chosen at start, and the result must match the comparator sequence. The two standalone pulse styles are reached by holding the chip lines fixed and shaping only readConv, so that the bus behaviour at completion shows whether a read request was already pending.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  // Strobes from the sequencing control to the conversion datapath
  typedef struct packed {
    logic start;   // load MSB trial, clear mask history
    logic step;    // resolve the current trial bit this cycle
    logic last;    // this step is the final decision
    logic readEn;  // a read is granted and may drive the bus
  } sar_strobe_t;

endpackage

// File: rtl/adc_bus_control.sv
module adc_bus_control
  import adc_bus_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chipEn,
  input  logic        chipSelN,
  input  logic        readConv,
  input  logic        byteSel,
  output sar_strobe_t stb,
  output logic        busy
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic {S_IDLE, S_CONV} ctrl_state_t;

  ctrl_state_t        state;
  logic [CNT_W-1:0]   stepsLeft;
  logic               convReq;
  logic               readReq;
  logic               convPrev;
  logic               startHit;
  logic               converting;

  assign convReq    = chipEn & ~chipSelN & ~readConv;
  assign readReq    = chipEn & ~chipSelN &  readConv;
  assign converting = (state == S_CONV);
  // start only on a new request edge while idle
  assign startHit   = convReq & ~convPrev & ~converting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      stepsLeft <= '0;
      convPrev  <= 1'b0;
    end else begin
      convPrev <= convReq;
      case (state)
        S_IDLE: begin
          if (startHit) begin
            state     <= S_CONV;
            stepsLeft <= byteSel ? CNT_W'(SHORT_W) : CNT_W'(DATA_W);
          end
        end
        S_CONV: begin
          stepsLeft <= stepsLeft - CNT_W'(1);
          if (stepsLeft == CNT_W'(1)) begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.start  = startHit;
    stb.step   = converting;
    stb.last   = converting && (stepsLeft == CNT_W'(1));
    stb.readEn = readReq & ~converting;
  end

  assign busy = converting;

endmodule

// File: rtl/adc_bus_datapath.sv
module adc_bus_datapath
  import adc_bus_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sar_strobe_t       stb,
  input  logic              cmpIn,
  input  logic              fullWidth,
  input  logic              byteSel,
  output logic [DATA_W-1:0] lineOut,
  output logic [DATA_W-1:0] lineDrv
);

  localparam int LO_W = DATA_W - SHORT_W;
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trialReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] decided;

  // keep or drop the bit under test according to the comparator
  assign decided = cmpIn ? trialReg : (trialReg & ~maskReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trialReg  <= '0;
      maskReg   <= '0;
      resultReg <= '0;
    end else if (stb.start) begin
      trialReg <= MSB_ONE;
      maskReg  <= MSB_ONE;
    end else if (stb.step) begin
      maskReg <= maskReg >> 1;
      if (stb.last) begin
        trialReg  <= decided;
        resultReg <= decided;
      end else begin
        trialReg <= decided | (maskReg >> 1);
      end
    end
  end

  // per-line lane selection for the three read formats
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    localparam bit IS_HI   = (i >= LO_W);
    localparam bit IN_LOWB = (i < SHORT_W);
    logic laneOn;
    logic laneZero;
    always_comb begin
      laneOn   = stb.readEn & (fullWidth |
                               (~byteSel & IS_HI) |
                               ( byteSel & IN_LOWB));
      laneZero = ~fullWidth & byteSel & IS_HI;
      lineDrv[i] = laneOn;
      lineOut[i] = laneOn & ~laneZero & resultReg[i];
    end
  end

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipEn,
  input  logic              chipSelN,
  input  logic              readConv,
  input  logic              byteSel,
  input  logic              fullWidth,
  input  logic              cmpIn,
  output logic              busy,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataDrv
);

  sar_strobe_t stb;

  adc_bus_control #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .chipEn   (chipEn),
    .chipSelN (chipSelN),
    .readConv (readConv),
    .byteSel  (byteSel),
    .stb      (stb),
    .busy     (busy)
  );

  adc_bus_datapath #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .cmpIn     (cmpIn),
    .fullWidth (fullWidth),
    .byteSel   (byteSel),
    .lineOut   (dataOut),
    .lineDrv   (dataDrv)
  );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chipEn,
  input logic              chipSelN,
  input logic              readConv,
  input logic              byteSel,
  input logic              fullWidth,
  input logic              busy,
  input logic [DATA_W-1:0] dataOut,
  input logic [DATA_W-1:0] dataDrv
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int LO_W  = DATA_W - SHORT_W;
  localparam logic [DATA_W-1:0] UPPER_MASK = {{SHORT_W{1'b1}}, {LO_W{1'b0}}};

  logic             convNow;
  logic             readNow;
  logic             convSeen;
  logic             armed;
  logic             shortCap;
  logic             newStart;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] expLast;

  assign convNow  = chipEn & ~chipSelN & ~readConv;
  assign readNow  = chipEn & ~chipSelN &  readConv;
  assign newStart = armed & convNow & ~convSeen & ~busy;
  assign expLast  = shortCap ? CNT_W'(SHORT_W - 1) : CNT_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      convSeen <= 1'b0;
      shortCap <= 1'b0;
      runCnt   <= '0;
    end else begin
      armed    <= 1'b1;
      convSeen <= convNow;
      if (newStart) begin
        runCnt   <= '0;
        shortCap <= byteSel;
      end else if (busy) begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    newStart |=> busy);

  p_len_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt == expLast) |=> !busy);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt != expLast) |=> busy);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !readNow) |-> (dataDrv == '0));

  p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (readNow && !busy && fullWidth) |-> (&dataDrv));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (readNow && !busy && !fullWidth && !byteSel) |-> (dataDrv == UPPER_MASK));

  p_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (readNow && !busy && !fullWidth && byteSel) |->
      ((dataDrv[DATA_W-1:SHORT_W] == '0) && (&dataDrv[SHORT_W-1:0]) &&
       (dataOut[SHORT_W-1:LO_W] == '0)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && readNow && !busy && fullWidth &&
     $past(readNow && !busy && fullWidth)) |-> $stable(dataOut));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chipEn    (chipEn),
  .chipSelN  (chipSelN),
  .readConv  (readConv),
  .byteSel   (byteSel),
  .fullWidth (fullWidth),
  .busy      (busy),
  .dataOut   (dataOut),
  .dataDrv   (dataDrv)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chipEn = 1'b0;
  logic        chipSelN = 1'b1;
  logic        readConv = 1'b1;
  logic        byteSel = 1'b0;
  logic        fullWidth = 1'b1;
  logic        cmpIn = 1'b0;
  logic        busy;
  logic [11:0] dataOut;
  logic [11:0] dataDrv;

  always #(CLK_P/2) clk = ~clk;

  adc_bus_ctrl u_adc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .chipEn(chipEn), .chipSelN(chipSelN),
    .readConv(readConv), .byteSel(byteSel), .fullWidth(fullWidth),
    .cmpIn(cmpIn), .busy(busy), .dataOut(dataOut), .dataDrv(dataDrv)
  );

  typedef struct {
    string       tag;
    logic        expBusy;
    logic [11:0] expDrv;
    logic [11:0] expOut;
  } exp_t;

  exp_t q[$];
  event sampleEv;
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // driver side: queue an expectation, sampled 1 time unit after a negedge
  task automatic probe(string tag, logic b, logic [11:0] d, logic [11:0] o);
    exp_t e;
    #1;
    e.tag = tag; e.expBusy = b; e.expDrv = d; e.expOut = o;
    q.push_back(e);
    ->sampleEv;
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (busy !== e.expBusy || dataDrv !== e.expDrv ||
            (dataOut & e.expDrv) !== e.expOut) begin
          bad++;
          $display("FAIL %s: actual busy=%0b drv=%h out=%h expected busy=%0b drv=%h out=%h",
                   e.tag, busy, dataDrv, dataOut & e.expDrv, e.expBusy, e.expDrv, e.expOut);
        end
      end
    end
  end

  // feed comparator decisions MSB first, one per cycle
  task automatic runBits(logic [11:0] pat, int n, bit rcHigh, bit disturb, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmpIn = pat[11-k];
      if (k == 0 && rcHigh) readConv = 1'b1;
      if (disturb && k == 2) begin chipEn = 1'b0; byteSel = ~byteSel; end
      if (disturb && k == 3) chipEn = 1'b1;
      if (k == 0) probe({tag, " R9 busy, bus idle"}, 1'b1, 12'h000, 12'h000);
      if (k == n-1) probe({tag, " R2 busy through last decision"}, 1'b1, 12'h000, 12'h000);
    end
    @(negedge clk);
  endtask

  initial begin
    // R4: reset state
    repeat (2) @(negedge clk);
    probe("R4 reset idle", 1'b0, 12'h000, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chipEn = 1'b1; chipSelN = 1'b0; readConv = 1'b1; fullWidth = 1'b1;
    probe("R4 reset result zero on R6 read", 1'b0, 12'hFFF, 12'h000);

    // conversion A: full, chip enable last
    @(negedge clk);
    chipEn = 1'b0; chipSelN = 1'b0; readConv = 1'b0; byteSel = 1'b0;
    @(negedge clk);
    chipEn = 1'b1;
    runBits(12'hA5C, 12, 1'b0, 1'b0, "R1 convA");
    probe("R4 busy cleared after 12", 1'b0, 12'h000, 12'h000);
    repeat (2) @(negedge clk);
    probe("R1 held request no retrigger", 1'b0, 12'h000, 12'h000);
    @(negedge clk);
    readConv = 1'b1;
    probe("R6 R3 full read A", 1'b0, 12'hFFF, 12'hA5C);
    @(negedge clk);
    probe("R5 repeated read A", 1'b0, 12'hFFF, 12'hA5C);
    @(negedge clk);
    fullWidth = 1'b0; byteSel = 1'b0;
    probe("R7 upper byte A", 1'b0, 12'hFF0, 12'hA50);
    @(negedge clk);
    byteSel = 1'b1;
    probe("R8 low nibble A", 1'b0, 12'h0FF, 12'h00C);
    @(negedge clk);
    chipSelN = 1'b1;
    probe("R9 deselected read", 1'b0, 12'h000, 12'h000);

    // conversion B: short, chip select last
    @(negedge clk);
    chipEn = 1'b1; readConv = 1'b0; byteSel = 1'b1; fullWidth = 1'b1;
    @(negedge clk);
    chipSelN = 1'b0;
    runBits(12'h3C7, 8, 1'b0, 1'b0, "R1 convB");
    probe("R2 short cycle done after 8", 1'b0, 12'h000, 12'h000);
    @(negedge clk);
    readConv = 1'b1;
    probe("R3 short result low bits zero", 1'b0, 12'hFFF, 12'h3C0);

    // conversion C: full, read/convert last, disturbed mid-run
    @(negedge clk);
    byteSel = 1'b0; readConv = 1'b0;
    runBits(12'h5E1, 12, 1'b0, 1'b1, "R10 convC");
    probe("R10 no restart, done after 12", 1'b0, 12'h000, 12'h000);
    @(negedge clk);
    readConv = 1'b1;
    probe("R2 R3 disturbed full result", 1'b0, 12'hFFF, 12'h5E1);

    // standalone: short low pulse on readConv
    @(negedge clk);
    byteSel = 1'b0; readConv = 1'b0;
    runBits(12'h0F3, 12, 1'b1, 1'b0, "R11 low pulse");
    probe("R11 bus driven at completion", 1'b0, 12'hFFF, 12'h0F3);

    // standalone: readConv left low after its falling edge
    @(negedge clk);
    readConv = 1'b0;
    runBits(12'h801, 12, 1'b0, 1'b0, "R11 held low");
    probe("R11 bus undriven while readConv low", 1'b0, 12'h000, 12'h000);
    @(negedge clk);
    readConv = 1'b1;
    probe("R11 bus driven after readConv high", 1'b0, 12'hFFF, 12'h801);
    @(negedge clk);
    chipSelN = 1'b1;
    @(negedge clk);
    chipSelN = 1'b0;
    probe("R5 result held across deselect", 1'b0, 12'hFFF, 12'h801);

    // short cycle with all-ones comparator, then byte reads
    @(negedge clk);
    byteSel = 1'b1; readConv = 1'b0;
    runBits(12'hFFF, 8, 1'b0, 1'b0, "R2 convD");
    probe("R2 short all ones done", 1'b0, 12'h000, 12'h000);
    @(negedge clk);
    readConv = 1'b1; fullWidth = 1'b0; byteSel = 1'b1;
    probe("R8 low nibble after short", 1'b0, 12'h0FF, 12'h000);
    @(negedge clk);
    byteSel = 1'b0;
    probe("R7 upper byte after short", 1'b0, 12'hFF0, 12'hFF0);

    #2;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (R1..R11 run): actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule